// File: doc/BRIEF.md
# PHY Delay Register Access Port

This block puts a bank of per-speed-mode I/O delay settings behind a single 32-bit control word in a host register space. Software never addresses a delay setting directly. It places a bank index and a data byte in the control word, then raises a write strobe bit. The block commits the byte on the 0-to-1 transition of that bit and raises an acknowledge bit. A read strobe works the same way: its rising edge copies the indexed setting into a read-data field of the same word.

The bank has nine entries, which feed the I/O timing logic in parallel. Each entry is loaded with its default value on synchronous reset. The control word is a plain register slot and has no flow control. A bus write lands in one clock. The bus read path is combinational, so the result depends only on the address.

Top module: `phy_dly_port`

## Requirements
- R1: After synchronous reset, the entries hold their defaults: index 0 and index 1 hold 4, index 6 holds 9, index 7 holds 2, index 8 holds 3, and indices 2 to 5 hold 0. At the same time the control word reads back as zero, acknowledge included.
- R2: The control word answers only at byte offset 0x10. A bus read at any other offset returns zero, and a bus write at any other offset changes nothing.
- R3: The layout of a written word is: index in bits [7:0], data byte in bits [15:8], write strobe in bit 24, read strobe in bit 25. A read-back word shows the index in [7:0], the read data in [19:12], the write strobe in bit 24, the read strobe in bit 25 and the acknowledge in bit 26. Every other read-back bit is zero.
- R4: A bus write that takes the write strobe from 0 to 1 commits the data byte into the indexed entry one clock later. The commit uses the index and data captured with that write, even if the word is rewritten in the very next clock.
- R5: While the write strobe stays set, further writes to the word commit nothing, whatever index or data they carry.
- R6: The acknowledge goes high in the clock after an accepted strobe edge. It holds while either strobe remains set and drops one clock after both strobes read zero.
- R7: A 0-to-1 transition of the read strobe loads the indexed entry into the read-data field one clock later. The field keeps that value until the next accepted read.
- R8: An index above 8 is acknowledged like any other. A write to such an index changes no entry, and a read of it returns zero.
- R9: When both strobes rise in the same bus write, only the write is performed: the read-data field is unchanged and the acknowledge still rises.
- R10: Entry i is driven on `dly_o[i*8 +: 8]` at all times.
- R11: Asserting reset at any moment, even with a transfer in progress, restores every entry to its R1 default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Bus write enable for one clock |
| reg_addr | input | 8 | Bus byte address |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data, combinational from `reg_addr` |
| dly_o | output | 72 | Nine 8-bit delay entries, entry i at bits [i*8 +: 8] |

## Verification
A strobe commit and a fresh bus write to the control word can fall in the same clock. The commit must use the index and data latched with the rising strobe, not the values arriving in that clock. The bench provokes this by issuing a strobe-set write followed at once by a strobe-clear write carrying a different index and data. It then checks that only the first index changed, that the acknowledge was high for exactly one clock, and that a second rising edge is still needed for the next commit. Both strobes rising together is provoked the same way, and is judged by the read-data field staying put while the entry updates.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  localparam int IDX_W     = 8;
  localparam int BYTE_W    = 8;
  localparam int F_IDX_LSB = 0;
  localparam int F_WD_LSB  = 8;
  localparam int F_RD_LSB  = 12;
  localparam int B_WSTB    = 24;
  localparam int B_RSTB    = 25;
  localparam int B_ACK     = 26;

  // default delay setting for a bank index
  function automatic int dly_default(input int idx);
    case (idx)
      0, 1:    return 4;
      6:       return 9;
      7:       return 2;
      8:       return 3;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_port_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PORT_OFS = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              hit,
  output logic [IDX_W-1:0]  idx_q,
  output logic [BYTE_W-1:0] wdat_q,
  output logic              wstb_q,
  output logic              rstb_q
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(PORT_OFS);

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:B_ACK], reg_wdata[B_WSTB-1:F_WD_LSB+BYTE_W]};

  assign hit = (reg_addr == OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      wdat_q <= '0;
      wstb_q <= 1'b0;
      rstb_q <= 1'b0;
    end else if (reg_wr && hit) begin
      idx_q  <= reg_wdata[F_IDX_LSB +: IDX_W];
      wdat_q <= reg_wdata[F_WD_LSB +: BYTE_W];
      wstb_q <= reg_wdata[B_WSTB];
      rstb_q <= reg_wdata[B_RSTB];
    end
  end
endmodule

// File: rtl/phy_strobe_edge.sv
module phy_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic wstb,
  input  logic rstb,
  output logic wr_fire,
  output logic rd_fire,
  output logic ack
);
  logic wstb_d, rstb_d;
  logic w_rise, r_rise;

  assign w_rise  = wstb & ~wstb_d;
  assign r_rise  = rstb & ~rstb_d;
  assign wr_fire = w_rise;
  assign rd_fire = r_rise & ~w_rise;   // write wins a simultaneous rise

  always_ff @(posedge clk) begin
    if (rst) begin
      wstb_d <= 1'b0;
      rstb_d <= 1'b0;
      ack    <= 1'b0;
    end else begin
      wstb_d <= wstb;
      rstb_d <= rstb;
      if (w_rise || r_rise)
        ack <= 1'b1;
      else if (!(wstb || rstb))
        ack <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
  import phy_port_pkg::*;
#(
  parameter int NUM_DLY = 9,
  parameter int DLY_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [DLY_W-1:0]         wdat,
  output logic [DLY_W-1:0]         rdat,
  output logic [NUM_DLY*DLY_W-1:0] flat
);
  logic [DLY_W-1:0] ent [NUM_DLY];

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_ent
    localparam logic [DLY_W-1:0] RST_V = DLY_W'(dly_default(g));
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= RST_V;
      else if (we && idx == IDX_W'(g))
        ent[g] <= wdat;
    end
    assign flat[g*DLY_W +: DLY_W] = ent[g];
  end

  always_comb begin
    rdat = '0;
    for (int i = 0; i < NUM_DLY; i++)
      if (idx == IDX_W'(i)) rdat = ent[i];
  end
endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
  import phy_port_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PORT_OFS = 'h10,
  parameter int NUM_DLY  = 9,
  parameter int DLY_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NUM_DLY*DLY_W-1:0] dly_o
);
  logic              hit;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] wdat_q;
  logic              wr_lvl, rd_lvl;
  logic              wr_fire, rd_fire, ack_q;
  logic [DLY_W-1:0]  bank_rd;
  logic [BYTE_W-1:0] rdat_q;

  phy_ctl_regs #(.ADDR_W(ADDR_W), .PORT_OFS(PORT_OFS)) u_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hit(hit), .idx_q(idx_q), .wdat_q(wdat_q),
    .wstb_q(wr_lvl), .rstb_q(rd_lvl)
  );

  phy_strobe_edge u_edge (
    .clk(clk), .rst(rst), .wstb(wr_lvl), .rstb(rd_lvl),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .ack(ack_q)
  );

  phy_delay_bank #(.NUM_DLY(NUM_DLY), .DLY_W(DLY_W)) u_bank (
    .clk(clk), .rst(rst), .we(wr_fire), .idx(idx_q),
    .wdat(DLY_W'(wdat_q)), .rdat(bank_rd), .flat(dly_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          rdat_q <= '0;
    else if (rd_fire) rdat_q <= BYTE_W'(bank_rd);
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      reg_rdata[F_IDX_LSB +: IDX_W] = idx_q;
      reg_rdata[F_RD_LSB +: BYTE_W] = rdat_q;
      reg_rdata[B_WSTB]             = wr_lvl;
      reg_rdata[B_RSTB]             = rd_lvl;
      reg_rdata[B_ACK]              = ack_q;
    end
  end
endmodule

// File: rtl/phy_dly_port_chk.sv
module phy_dly_port_chk #(
  parameter int NUM_DLY = 9,
  parameter int DLY_W   = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_lvl,
  input logic                     rd_lvl,
  input logic                     wr_fire,
  input logic                     rd_fire,
  input logic                     ack,
  input logic [7:0]               rdat,
  input logic [NUM_DLY*DLY_W-1:0] dly_o
);
  AST_ACK_AFTER_WEDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_lvl) |=> ack); // R6
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack && (wr_lvl || rd_lvl)) |=> ack); // R6
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    !(wr_lvl || rd_lvl) |=> !ack); // R6
  AST_NO_COMMIT_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$rose(wr_lvl) |=> $stable(dly_o)); // R5
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rdat)); // R7
  AST_BOTH_RISE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_lvl) && $rose(rd_lvl)) |=> $stable(rdat)); // R9
  AST_FIRE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_fire, rd_fire})); // R9
endmodule

bind phy_dly_port phy_dly_port_chk #(.NUM_DLY(NUM_DLY), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .wr_lvl(wr_lvl), .rd_lvl(rd_lvl), .wr_fire(wr_fire),
  .rd_fire(rd_fire), .ack(ack_q), .rdat(rdat_q), .dly_o(dly_o)
);

// File: tb/tb_phy_dly_port.sv
module tb_phy_dly_port;
  localparam int NUM = 9;
  localparam logic [7:0] OFS = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM*8-1:0] dly_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_dly [NUM];
  logic [7:0] exp_rd;

  always #2 clk = ~clk;

  phy_dly_port dut (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
                    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dly_o(dly_o));

  function automatic logic [7:0] def_val(int i);
    case (i) 0, 1: return 8'd4; 6: return 8'd9; 7: return 8'd2; 8: return 8'd3;
      default: return 8'd0; endcase
  endfunction

  function automatic logic [31:0] mk_word(logic [7:0] idx, logic [7:0] d, bit w, bit r);
    return {6'd0, r, w, 8'd0, d, idx};
  endfunction

  function automatic logic [31:0] exp_rb(logic [7:0] idx, logic [7:0] rd, bit w, bit r, bit a);
    return {5'd0, a, r, w, 4'd0, rd, 4'd0, idx};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM; i++) exp_dly[i] = def_val(i);
    exp_rd = 8'd0;
  endtask

  task automatic check_bank(string req);
    for (int i = 0; i < NUM; i++) check(req, 32'(dly_o[i*8 +: 8]), 32'(exp_dly[i]));
  endtask

  task automatic rd_word(logic [7:0] a, output logic [31:0] v);
    reg_addr = a; #0.5; v = reg_rdata; reg_addr = OFS;
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] w);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = OFS;
  endtask

  logic [31:0] rb;

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10 reset state
    check_bank("R1 R10 reset defaults");
    rd_word(OFS, rb); check("R1 reset word", rb, 32'd0);

    // R2 other offset: read zero, write ignored
    bus_write(8'h14, mk_word(8'h02, 8'hAA, 1, 0));
    @(negedge clk);
    rd_word(8'h14, rb); check("R2 off-offset read", rb, 32'd0);
    rd_word(OFS, rb);   check("R2 off-offset write ignored", rb, 32'd0);
    check_bank("R2 bank unchanged");

    // R4 same-cycle: set strobe, then immediately rewrite word with strobe clear
    reg_wr = 1'b1; reg_addr = OFS; reg_wdata = mk_word(8'h03, 8'h5C, 1, 0);
    @(negedge clk);
    reg_wdata = mk_word(8'h04, 8'hE1, 0, 0);
    @(negedge clk);
    reg_wr = 1'b0;
    exp_dly[3] = 8'h5C;
    check_bank("R4 commit uses latched index/data");
    rd_word(OFS, rb); check("R6 ack after edge", rb, exp_rb(8'h04, exp_rd, 0, 0, 1));
    @(negedge clk);
    rd_word(OFS, rb); check("R6 ack dropped", rb, exp_rb(8'h04, exp_rd, 0, 0, 0));

    // R5 strobe held: second write commits nothing
    bus_write(OFS, mk_word(8'h02, 8'h11, 1, 0));
    @(negedge clk);
    exp_dly[2] = 8'h11;
    bus_write(OFS, mk_word(8'h05, 8'h22, 1, 0));
    repeat (2) @(negedge clk);
    check_bank("R5 held strobe no commit");
    rd_word(OFS, rb); check("R6 ack holds while set", rb, exp_rb(8'h05, exp_rd, 1, 0, 1));
    bus_write(OFS, mk_word(8'h05, 8'h22, 0, 0));
    @(negedge clk);

    // R9 both strobes together
    bus_write(OFS, mk_word(8'h06, 8'h77, 0, 1));
    @(negedge clk);
    exp_rd = exp_dly[6];
    rd_word(OFS, rb); check("R7 read latch", rb, exp_rb(8'h06, exp_rd, 0, 1, 1));
    bus_write(OFS, mk_word(8'h06, 8'h77, 0, 0));
    @(negedge clk);
    bus_write(OFS, mk_word(8'h01, 8'h3D, 1, 1));
    @(negedge clk);
    exp_dly[1] = 8'h3D;
    rd_word(OFS, rb); check("R9 write wins, read ignored", rb, exp_rb(8'h01, exp_rd, 1, 1, 1));
    check_bank("R9 write committed");
    bus_write(OFS, 32'd0);
    @(negedge clk);

    // random mix, R3 R4 R6 R7 R8
    for (int n = 0; n < 150; n++) begin
      logic [7:0] a, d;
      int op;
      a  = 8'($urandom % 12);
      d  = 8'($urandom);
      op = int'($urandom % 3);
      bus_write(OFS, mk_word(a, d, op != 1, op != 0));
      @(negedge clk);
      if (op != 1 && a < NUM) exp_dly[a] = d;
      if (op == 1) exp_rd = (a < NUM) ? exp_dly[a] : 8'd0;
      rd_word(OFS, rb);
      check((a >= NUM) ? "R8 out-of-range acked" : "R3 R7 readback",
            rb, exp_rb(a, exp_rd, op != 1, op != 0, 1));
      check_bank("R4 R8 bank after random op");
      bus_write(OFS, mk_word(a, d, 0, 0));
      @(negedge clk);
      rd_word(OFS, rb); check("R6 ack clears", rb, exp_rb(a, exp_rd, 0, 0, 0));
    end

    // R11 reset mid-transfer
    bus_write(OFS, mk_word(8'h07, 8'hC4, 1, 0));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model_reset();
    check_bank("R11 reset mid-transfer");
    rd_word(OFS, rb); check("R11 word cleared", rb, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule